// File: doc/BRIEF.md
# Receiver Loopback Training Sequencer

This block drives the pattern-generator side of a receiver bit error test. Once started, it waits for line activity from the link partner and holds off a fixed settling delay. It then walks four handshake phases. Each phase raises a request to an external signalling engine and moves on when that engine acknowledges. A programmable limit bounds how long each phase may wait for its acknowledge. If the limit runs out, the run ends at once with a fail code that names the stalled phase.

After the handshakes, the sequencer emits one block per clock towards the serializer, as a type code with a valid strobe. First comes an exact count of equalisation training blocks, then first training ordered sets, then second training ordered sets with the loopback request set. Last comes the pattern run. The pattern run is a fixed number of data blocks with one skip ordered set slipped in after every fixed group of data blocks.

One cycle after the last data block, the sequencer judges the run from the error count supplied by the error detector and from whether the partner was seen in loopback during the pattern. It then holds done and the verdict until the next start. Every count and delay is a parameter, so a small configuration gives short runs.

Top module: `lbk_train_seq`

## Requirements
- R1: After reset, hs_req_o, blk_valid_o, done_o and pass_o are low, and nothing happens until start_i is high in a cycle.
- R2: After start, the sequencer waits for activity_i. The first handshake request rises exactly DELAY_CYC cycles after the clock edge that samples activity_i high.
- R3: The handshake phases run in the order hs_phase_o = 0 (polling signalling), 1 (extended signalling), 2 (port match), 3 (port configuration). Each phase advances on the edge that samples hs_ack_i high while hs_req_o is high.
- R4: The request of a phase goes up at cycle 0. An acknowledge sampled at cycle d with d <= tmo_limit_i is accepted. If no acknowledge comes by cycle tmo_limit_i, the run ends with done_o high, pass_o low, fail_code_o = phase + 1, and no block emitted.
- R5: After the last handshake, exactly TSEQ_N blocks of type code 1 (equalisation training) are emitted, one per cycle with blk_valid_o high.
- R6: Next come exactly TS1_N blocks of type code 2, then exactly TS2_N blocks of type code 3 (second training set with the loopback request set), with no interleaving.
- R7: The pattern run emits exactly PAT_N blocks of type code 4 (data). One block of type code 5 (skip set) follows each group of SKP_EVERY data blocks, no skip set follows the final data block, and two skip sets are never adjacent.
- R8: A run that has passed all handshakes finishes with done_o high. pass_o is high and fail_code_o = 0 only when lpbk_i was high in at least one pattern cycle and err_cnt_i <= 1 at evaluation. Otherwise fail_code_o = 5 when loopback was never seen, and else 6 for too many errors.
- R9: The verdict outputs hold steady until start_i is high again, and a new start runs the full sequence again from the activity wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a test run |
| activity_i | input | 1 | Line activity seen from the partner |
| tmo_limit_i | input | TW | Handshake timeout limit in cycles |
| hs_ack_i | input | 1 | Handshake acknowledge from the signalling engine |
| lpbk_i | input | 1 | Partner reported in loopback |
| err_cnt_i | input | EW | Error count from the error detector |
| hs_req_o | output | 1 | Handshake request |
| hs_phase_o | output | 2 | Current handshake phase |
| blk_valid_o | output | 1 | Block type valid this cycle |
| blk_type_o | output | 3 | Block type code to the serializer |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run passed |
| fail_code_o | output | 3 | Reason code, 0 on pass |

## Verification
The bench goes after acknowledges that land exactly on the timeout limit and one cycle past it, in every phase. A design with an off-by-one timer would fail a legal handshake or accept a late one, and a wrong phase code would name the wrong stall. It counts every block type over whole runs, and checks that the last pattern block is data and that skip sets come after exactly SKP_EVERY data blocks. An off-by-one emit counter or a trailing skip set would show up in those counts. It also sweeps the error count across the pass limit of one and runs with loopback never reported, where a wrong comparison would pass a run with two errors.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WACT, ST_DLY, ST_HS, ST_TSEQ,
        ST_TS1, ST_TS2, ST_PAT, ST_EVAL, ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        BT_NONE = 3'd0,
        BT_TSEQ = 3'd1,
        BT_TS1  = 3'd2,
        BT_TS2L = 3'd3,
        BT_DATA = 3'd4,
        BT_SKP  = 3'd5
    } blk_type_e;

    localparam logic [2:0] FC_PASS    = 3'd0;
    localparam logic [2:0] FC_NO_LPBK = 3'd5;
    localparam logic [2:0] FC_ERRORS  = 3'd6;

endpackage

// File: rtl/lbk_hs_timer.sv
module lbk_hs_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (cnt_q != limit_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = !clr_i && (cnt_q == limit_i);

    // R4: the timer never passes the limit
    p_timer_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cnt_q == limit_i && $stable(limit_i)) |=> (clr_i || cnt_q == $past(cnt_q)));
endmodule

// File: rtl/lbk_skp_pacer.sv
module lbk_skp_pacer #(
    parameter int SKP_EVERY = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic skp_now_o
);
    localparam int GW = $clog2(SKP_EVERY + 1) + 1;

    logic [GW-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (!run_i || skp_now_o) gap_d = '0;
        else                     gap_d = gap_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    assign skp_now_o = run_i && (gap_q == GW'(SKP_EVERY));

    // R7: a skip set is always followed by a data block or the end of the run
    p_no_double_skp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        skp_now_o |=> !skp_now_o);
endmodule

// File: rtl/lbk_train_seq.sv
module lbk_train_seq
    import lbk_pkg::*;
#(
    parameter int DELAY_CYC = 16000,
    parameter int TSEQ_N    = 524288,
    parameter int TS1_N     = 256,
    parameter int TS2_N     = 256,
    parameter int PAT_N     = 90909091,
    parameter int SKP_EVERY = 21,
    parameter int MAX_ERR   = 1,
    parameter int TW        = 12,
    parameter int EW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          activity_i,
    input  logic [TW-1:0] tmo_limit_i,
    input  logic          hs_ack_i,
    input  logic          lpbk_i,
    input  logic [EW-1:0] err_cnt_i,
    output logic          hs_req_o,
    output logic [1:0]    hs_phase_o,
    output logic          blk_valid_o,
    output logic [2:0]    blk_type_o,
    output logic          done_o,
    output logic          pass_o,
    output logic [2:0]    fail_code_o
);
    localparam int CW = $clog2(TSEQ_N + TS1_N + TS2_N + PAT_N + DELAY_CYC + 1) + 1;

    typedef struct packed {
        seq_state_e    st;
        logic [1:0]    phase;
        logic [CW-1:0] cnt;
        logic          lb_seen;
        logic [2:0]    code;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      tmo_hit, skp_now, in_pat, tmr_clr;

    assign in_pat  = (r_q.st == ST_PAT);
    assign tmr_clr = (r_q.st != ST_HS) || hs_ack_i;

    lbk_hs_timer #(.TW(TW)) i_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr),
        .limit_i(tmo_limit_i), .expired_o(tmo_hit)
    );

    lbk_skp_pacer #(.SKP_EVERY(SKP_EVERY)) i_pacer (
        .clk(clk), .rst_n(rst_n), .run_i(in_pat), .skp_now_o(skp_now)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: if (start_i) begin
                r_d.st   = ST_WACT;
                r_d.code = FC_PASS;
            end
            ST_WACT: if (activity_i) begin
                r_d.st  = ST_DLY;
                r_d.cnt = '0;
            end
            ST_DLY: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(DELAY_CYC - 1)) begin
                    r_d.st    = ST_HS;
                    r_d.phase = 2'd0;
                    r_d.cnt   = '0;
                end
            end
            ST_HS: begin
                if (hs_ack_i) begin
                    r_d.phase = r_q.phase + 1'b1;
                    if (r_q.phase == 2'd3) r_d.st = ST_TSEQ;
                end else if (tmo_hit) begin
                    r_d.st   = ST_DONE;
                    r_d.code = {1'b0, r_q.phase} + 3'd1;
                end
            end
            ST_TSEQ: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(TSEQ_N - 1)) begin
                    r_d.st  = ST_TS1;
                    r_d.cnt = '0;
                end
            end
            ST_TS1: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(TS1_N - 1)) begin
                    r_d.st  = ST_TS2;
                    r_d.cnt = '0;
                end
            end
            ST_TS2: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(TS2_N - 1)) begin
                    r_d.st      = ST_PAT;
                    r_d.cnt     = '0;
                    r_d.lb_seen = 1'b0;
                end
            end
            ST_PAT: begin
                if (lpbk_i) r_d.lb_seen = 1'b1;
                if (!skp_now) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CW'(PAT_N - 1)) r_d.st = ST_EVAL;
                end
            end
            ST_EVAL: begin
                r_d.st = ST_DONE;
                if (!r_q.lb_seen)                     r_d.code = FC_NO_LPBK;
                else if (err_cnt_i > EW'(MAX_ERR))    r_d.code = FC_ERRORS;
                else                                  r_d.code = FC_PASS;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.phase   <= '0;
            r_q.cnt     <= '0;
            r_q.lb_seen <= 1'b0;
            r_q.code    <= FC_PASS;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        blk_valid_o = 1'b1;
        unique case (r_q.st)
            ST_TSEQ: blk_type_o = BT_TSEQ;
            ST_TS1:  blk_type_o = BT_TS1;
            ST_TS2:  blk_type_o = BT_TS2L;
            ST_PAT:  blk_type_o = skp_now ? BT_SKP : BT_DATA;
            default: begin
                blk_type_o  = BT_NONE;
                blk_valid_o = 1'b0;
            end
        endcase
    end

    assign hs_req_o    = (r_q.st == ST_HS);
    assign hs_phase_o  = r_q.phase;
    assign done_o      = (r_q.st == ST_DONE);
    assign pass_o      = done_o && (r_q.code == FC_PASS);
    assign fail_code_o = done_o ? r_q.code : 3'd0;

    // R3: phase stays or steps up by one while requesting
    p_phase_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req_o && $past(hs_req_o)) |-> (hs_phase_o == $past(hs_phase_o) + 2'd1 ||
                                           hs_phase_o == $past(hs_phase_o)));
    // R4: an unanswered expired request ends the run with a failing verdict
    p_timeout_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req_o && tmo_hit && !hs_ack_i) |=> (done_o && !pass_o && fail_code_o != 3'd0));
    // R5: handshake and block emission never overlap
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_req_o && blk_valid_o));
    // R8: a pass is only reported when finished
    p_pass_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (done_o && fail_code_o == 3'd0));
    // R9: verdict holds while no start arrives
    p_verdict_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(fail_code_o)));
endmodule

// File: tb/test_lbk_train_seq.sv
module test_lbk_train_seq;
    localparam int DLY = 5, NTSEQ = 16, NTS1 = 4, NTS2 = 4, NPAT = 50, EVERY = 21;
    localparam int TW = 12, EW = 16;

    logic clk = 0, rst_n = 0;
    logic start_i = 0, activity_i = 0, hs_ack_i = 0, lpbk_i = 0;
    logic [TW-1:0] tmo_limit_i = 12'd3;
    logic [EW-1:0] err_cnt_i = '0;
    logic hs_req_o, blk_valid_o, done_o, pass_o;
    logic [1:0] hs_phase_o;
    logic [2:0] blk_type_o, fail_code_o;

    int n_vec = 0, n_bad = 0;
    int c_tseq, c_ts1, c_ts2, c_dat, c_skp, run_dat, ord_bad, skp_bad, last_t, rank_q;

    always #2.5 clk = ~clk;

    lbk_train_seq #(.DELAY_CYC(DLY), .TSEQ_N(NTSEQ), .TS1_N(NTS1), .TS2_N(NTS2),
                    .PAT_N(NPAT), .SKP_EVERY(EVERY), .MAX_ERR(1), .TW(TW), .EW(EW))
    i_lbk_train_seq (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        c_tseq = 0; c_ts1 = 0; c_ts2 = 0; c_dat = 0; c_skp = 0;
        run_dat = 0; ord_bad = 0; skp_bad = 0; last_t = 0; rank_q = 0;
    endtask

    always @(negedge clk) if (rst_n && blk_valid_o) begin
        int rk;
        rk = (blk_type_o == 3'd5) ? 4 : int'(blk_type_o);
        if (rk < rank_q) ord_bad++;
        rank_q = rk;
        case (blk_type_o)
            3'd1: c_tseq++;
            3'd2: c_ts1++;
            3'd3: c_ts2++;
            3'd4: begin c_dat++; run_dat++; end
            3'd5: begin c_skp++; if (run_dat != EVERY) skp_bad++; run_dat = 0; end
            default: ord_bad++;
        endcase
        last_t = int'(blk_type_o);
    end

    // Start a run, give activity, and answer phases with given delays; stall_ph gets delay d_stall
    task automatic run(input int d_norm, input int stall_ph, input int d_stall,
                       input bit lb, input int errs, output bit hs_ok);
        clr_mon();
        err_cnt_i = EW'(errs);
        lpbk_i = lb;
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0; activity_i = 1;
        @(posedge clk);
        @(negedge clk) activity_i = 0;
        // R2: request low for DELAY_CYC negedges after the sampling edge
        for (int i = 1; i < DLY; i++) @(negedge clk);
        chk(!hs_req_o, "R2 req before delay", hs_req_o, 0);
        @(negedge clk);
        chk(hs_req_o, "R2 req after delay", hs_req_o, 1);
        hs_ok = 1;
        for (int p = 0; p < 4; p++) begin
            int d;
            d = (p == stall_ph) ? d_stall : d_norm;
            while (!hs_req_o && !done_o) @(negedge clk);
            if (done_o) begin hs_ok = 0; break; end
            chk(hs_phase_o == 2'(p), "R3 phase order", hs_phase_o, p);
            for (int k = 0; k < d; k++) begin
                @(negedge clk);
                if (done_o) break;
            end
            if (done_o) begin hs_ok = 0; break; end
            hs_ack_i = 1;
            @(negedge clk) hs_ack_i = 0;
        end
        while (!done_o) @(negedge clk);
    endtask

    initial begin
        bit ok;
        int exp_skp;
        exp_skp = (NPAT - 1) / EVERY;
        repeat (3) @(negedge clk);
        chk(!hs_req_o && !blk_valid_o && !done_o && !pass_o, "R1 reset state", done_o, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk(!hs_req_o && !blk_valid_o && !done_o, "R1 idle without start", hs_req_o, 0);

        // Full passing runs across error counts and ack delays
        for (int e = 0; e < 3; e++) begin
            for (int d = 0; d < 2; d++) begin
                run(d * 3, -1, 0, 1'b1, e, ok);
                chk(ok, "R4 ack at or before limit accepted", ok, 1);
                chk(c_tseq == NTSEQ, "R5 TSEQ count", c_tseq, NTSEQ);
                chk(c_ts1 == NTS1, "R6 TS1 count", c_ts1, NTS1);
                chk(c_ts2 == NTS2, "R6 TS2 count", c_ts2, NTS2);
                chk(ord_bad == 0, "R6 block order", ord_bad, 0);
                chk(c_dat == NPAT, "R7 data count", c_dat, NPAT);
                chk(c_skp == exp_skp, "R7 skip count", c_skp, exp_skp);
                chk(skp_bad == 0 && last_t == 4, "R7 skip spacing and tail", last_t, 4);
                chk(pass_o == (e <= 1), "R8 verdict", pass_o, e <= 1);
                chk(fail_code_o == ((e <= 1) ? 3'd0 : 3'd6), "R8 fail code", fail_code_o,
                    (e <= 1) ? 0 : 6);
                repeat (5) @(negedge clk);
                chk(done_o && fail_code_o == ((e <= 1) ? 3'd0 : 3'd6), "R9 verdict hold",
                    fail_code_o, (e <= 1) ? 0 : 6);
            end
        end

        // Loopback never reported
        run(1, -1, 0, 1'b0, 0, ok);
        chk(!pass_o && fail_code_o == 3'd5, "R8 no loopback", fail_code_o, 5);

        // Timeout sweep over phases and limits
        for (int lim = 0; lim < 3; lim++) begin
            tmo_limit_i = TW'(lim);
            for (int p = 0; p < 4; p++) begin
                run(0, p, lim + 1, 1'b1, 0, ok);
                chk(!ok && !pass_o, "R4 late ack fails", pass_o, 0);
                chk(fail_code_o == 3'(p + 1), "R4 timeout phase code", fail_code_o, p + 1);
                chk(c_tseq + c_ts1 + c_ts2 + c_dat + c_skp == 0, "R4 no blocks on timeout",
                    c_tseq, 0);
                run(0, p, lim, 1'b1, 0, ok);
                chk(ok && pass_o, "R4 ack on limit accepted", pass_o, 1);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule